// File: doc/BRIEF.md
# Serial EEPROM Byte Reader

This block fetches bytes from a serial EEPROM that is addressed with eight bits and uses a four-wire serial bus. The host gives a start address, a byte count and a command choice, then pulses `start`. The block can issue a data read or a status-register read. It returns each byte on `byte_data` together with a one-cycle `byte_valid` strobe. When the last byte has been delivered it pulses `done` for one cycle.

The block does not stream a burst. Every byte is fetched in its own complete bus transaction. Each transaction lowers chip select, sends the opcode, sends the address when the command is a data read, and clocks in one byte. The block then raises chip select for an idle gap and adds one to the address before the next transaction. The first request after reset is preceded by two dummy clock pulses with chip select held high.

Every serial-clock half period lasts `HALF_CLKS` system clocks. This sets the bus speed relative to the system clock.

Top module: `spi_rom_reader`

## Requirements
- R1: While the block is idle, and from reset onward, `rom_cs_n`=1, `rom_sck`=0 and `rom_mosi`=0.
- R2: The first accepted request after reset issues two `rom_sck` pulses (high half, then low half) with `rom_cs_n` high, before chip select first falls. Later requests issue no such pulses until the next reset.
- R3: Each transaction first shifts an 8-bit opcode MSB first on `rom_mosi`. The opcode is 8'h03 when `status_mode`=0 and 8'h05 when `status_mode`=1. `rom_mosi` changes only while `rom_sck` is low, so it is stable across every rising edge.
- R4: A data read sends the 8-bit byte address MSB first right after the opcode, for 24 clock pulses per transaction. A status read sends no address and uses 16 pulses.
- R5: The eight reply bits are sampled at the end of each low half of `rom_sck` and assembled MSB first. The byte appears on `byte_data` with a one-cycle `byte_valid` pulse.
- R6: A request for N bytes runs N separate transactions, and the address increases by one after each byte. Between transactions `rom_cs_n` stays high for exactly one half period while `rom_sck` is low.
- R7: Every high half of `rom_sck` lasts exactly `HALF_CLKS` clock cycles.
- R8: The address wraps from 8'hFF to 8'h00.
- R9: `busy` rises the cycle after an accepted `start` and stays high until the cycle in which `done` pulses for exactly one cycle. `done` follows the last `byte_valid`.
- R10: A `start` that arrives while `busy` is high has no effect.
- R11: A `start` with `byte_count`=0 produces `done` on the next cycle with `busy` held low and no activity on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| status_mode | input | 1 | 1 selects a status read, 0 selects a data read |
| start_addr | input | 8 | First byte address |
| byte_count | input | COUNT_W | Number of bytes to fetch |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Fetched byte |
| rom_cs_n | output | 1 | Chip select, active low |
| rom_sck | output | 1 | Serial clock |
| rom_mosi | output | 1 | Serial data to the memory |
| rom_miso | input | 1 | Serial data from the memory |

## Verification
The assertions check on every cycle that the bus is quiet while idle and that `rom_mosi` never moves during a clock-high phase. They also check that chip select falls only with the clock low, that `done` is a single-cycle pulse outside `busy`, and that zero-count and normal starts produce their immediate responses. Some behaviours can only be shown by the bench, which runs a behavioural memory on the bus: the opcode and address bit order, the sampling point of the reply bits, the half-period length, the gap between transactions, the once-only preamble, and the address sweep across all 256 locations with wrap.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_XFER, ST_GAP} rd_state_t;
  localparam logic [7:0] OP_DATA = 8'h03;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam int PRE_STEPS = 4;
endpackage

// File: rtl/rom_half_timer.sv
module rom_half_timer #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_CLKS - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rom_shift_reg.sv
module rom_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[W-2:0], sin};
    else            q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/spi_rom_reader.sv
module spi_rom_reader
  import rom_rd_pkg::*;
#(
  parameter int HALF_CLKS = 4,
  parameter int COUNT_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               status_mode,
  input  logic [7:0]         start_addr,
  input  logic [COUNT_W-1:0] byte_count,
  output logic               busy,
  output logic               done,
  output logic               byte_valid,
  output logic [7:0]         byte_data,
  output logic               rom_cs_n,
  output logic               rom_sck,
  output logic               rom_mosi,
  input  logic               rom_miso
);
  localparam int TX_W   = 16;
  localparam int STEP_W = 6;

  rd_state_t          state_q, state_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [7:0]         addr_q, addr_d;
  logic [COUNT_W-1:0] left_q, left_d;
  logic               stat_q, stat_d;
  logic               pre_q, pre_d;
  logic               done_q, done_d;
  logic               vld_q, vld_d;
  logic [7:0]         data_q, data_d;

  logic              tick, tx_load, tx_shift, rx_shift;
  logic [TX_W-1:0]   tx_q, tx_val;
  logic [7:0]        rx_q;
  logic [4:0]        bit_idx;
  logic              hi_half;
  logic [4:0]        tx_bits;
  logic [STEP_W-1:0] last_step;
  logic [7:0]        ld_addr;
  logic              ld_stat;

  assign bit_idx   = step_q[STEP_W-1:1];
  assign hi_half   = step_q[0];
  assign tx_bits   = stat_q ? 5'd8 : 5'd16;
  assign last_step = stat_q ? STEP_W'(31) : STEP_W'(47);

  assign ld_addr = (state_q == ST_IDLE) ? start_addr : addr_q;
  assign ld_stat = (state_q == ST_IDLE) ? status_mode : stat_q;
  assign tx_val  = ld_stat ? {OP_STAT, 8'h00} : {OP_DATA, ld_addr};

  rom_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE), .tick(tick)
  );

  rom_shift_reg #(.W(TX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
    .shift(tx_shift), .sin(1'b0), .q(tx_q)
  );

  rom_shift_reg #(.W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val(8'h00),
    .shift(rx_shift), .sin(rom_miso), .q(rx_q)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    addr_d   = addr_q;
    left_d   = left_q;
    stat_d   = stat_q;
    pre_d    = pre_q;
    done_d   = 1'b0;
    vld_d    = 1'b0;
    data_d   = data_q;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (byte_count == '0) begin
          done_d = 1'b1;
        end else begin
          addr_d = start_addr;
          left_d = byte_count;
          stat_d = status_mode;
          step_d = '0;
          if (pre_q) begin
            state_d = ST_XFER;
            tx_load = 1'b1;
          end else begin
            state_d = ST_PRE;
          end
        end
      end
      ST_PRE: if (tick) begin
        if (step_q == STEP_W'(PRE_STEPS - 1)) begin
          state_d = ST_XFER;
          step_d  = '0;
          tx_load = 1'b1;
          pre_d   = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_XFER: if (tick) begin
        if (!hi_half) begin
          rx_shift = (bit_idx >= tx_bits);
          step_d   = step_q + 1'b1;
        end else if (step_q == last_step) begin
          state_d = ST_GAP;
          step_d  = '0;
          vld_d   = 1'b1;
          data_d  = rx_q;
          addr_d  = addr_q + 8'd1;
          left_d  = left_q - 1'b1;
        end else begin
          tx_shift = 1'b1;
          step_d   = step_q + 1'b1;
        end
      end
      ST_GAP: if (tick) begin
        if (left_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_XFER;
          tx_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      stat_q  <= 1'b0;
      pre_q   <= 1'b0;
      done_q  <= 1'b0;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      stat_q  <= stat_d;
      pre_q   <= pre_d;
      done_q  <= done_d;
      vld_q   <= vld_d;
      data_q  <= data_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign byte_valid = vld_q;
  assign byte_data  = data_q;
  assign rom_cs_n   = (state_q != ST_XFER);
  assign rom_sck    = ((state_q == ST_XFER) && hi_half) ||
                      ((state_q == ST_PRE) && !step_q[0]);
  assign rom_mosi   = (state_q == ST_XFER) && (bit_idx < tx_bits) && tx_q[TX_W-1];
endmodule

// File: rtl/spi_rom_reader_chk.sv
module spi_rom_reader_chk #(
  parameter int COUNT_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [COUNT_W-1:0] byte_count,
  input logic               busy,
  input logic               done,
  input logic               byte_valid,
  input logic               rom_cs_n,
  input logic               rom_sck,
  input logic               rom_mosi
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rom_cs_n && !rom_sck && !rom_mosi)); // R1
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sck && $past(rom_sck)) |-> $stable(rom_mosi)); // R3
  AST_CS_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_cs_n) |-> !rom_sck); // R6
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> busy); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count != '0) |=> busy); // R9
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> (done && !busy)); // R11
endmodule

bind spi_rom_reader spi_rom_reader_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
  .busy(busy), .done(done), .byte_valid(byte_valid),
  .rom_cs_n(rom_cs_n), .rom_sck(rom_sck), .rom_mosi(rom_mosi)
);

// File: tb/sim_spi_rom_reader.sv
module sim_spi_rom_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int CW = 9;
  localparam logic [7:0] STAT_VAL = 8'hC6;

  logic clk, rst_n, start, status_mode, busy, done, byte_valid;
  logic rom_cs_n, rom_sck, rom_mosi, rom_miso;
  logic [7:0] start_addr, byte_data;
  logic [CW-1:0] byte_count;

  int total, bad;
  int pre_rises, all_rises, frames, got, done_cnt;
  int m_nrise, m_idx, last_bits, hi_run, cs_run;
  logic [7:0] m_sh, m_op, m_addr, m_out, exp_addr;
  logic exp_stat, in_req, prev_cs;
  bit finished;

  spi_rom_reader #(.HALF_CLKS(HALF), .COUNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .status_mode(status_mode),
    .start_addr(start_addr), .byte_count(byte_count), .busy(busy),
    .done(done), .byte_valid(byte_valid), .byte_data(byte_data),
    .rom_cs_n(rom_cs_n), .rom_sck(rom_sck), .rom_mosi(rom_mosi),
    .rom_miso(rom_miso)
  );

  function automatic logic [7:0] mem_val(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory
  always @(posedge rom_sck) begin
    all_rises++;
    if (rom_cs_n) pre_rises++;
    else begin
      m_sh = {m_sh[6:0], rom_mosi};
      m_nrise++;
      if (m_nrise == 8) begin
        m_op = m_sh;
        if (m_sh == 8'h05) m_out = STAT_VAL;
      end
      if (m_nrise == 16 && m_op == 8'h03) begin
        m_addr = m_sh;
        m_out = mem_val(m_sh);
      end
    end
  end
  always @(negedge rom_sck) begin
    if (!rom_cs_n && m_idx < 8 &&
        ((m_op == 8'h05 && m_nrise >= 8) || (m_op == 8'h03 && m_nrise >= 16))) begin
      rom_miso = m_out[7 - m_idx];
      m_idx++;
    end
  end
  always @(negedge rom_cs_n) begin
    frames++; m_nrise = 0; m_idx = 0; m_op = 8'h00;
  end
  always @(posedge rom_cs_n) last_bits = m_nrise;

  // output monitor
  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin
      chk(m_op == (exp_stat ? 8'h05 : 8'h03), "R3 opcode", m_op, exp_stat ? 5 : 3);
      if (!exp_stat) chk(m_addr == exp_addr, "R6/R8 address", m_addr, exp_addr);
      chk(byte_data == (exp_stat ? STAT_VAL : mem_val(exp_addr)), "R5 data",
          byte_data, exp_stat ? STAT_VAL : mem_val(exp_addr));
      got++;
      exp_addr = exp_addr + 8'd1;
    end
    if (done) done_cnt++;
    if (rom_sck) hi_run++;
    else if (hi_run > 0) begin
      chk(hi_run == HALF, "R7 high half", hi_run, HALF);
      hi_run = 0;
    end
    if (rom_cs_n) cs_run++;
    else begin
      if (prev_cs && in_req && got > 0) chk(cs_run == HALF, "R6 gap", cs_run, HALF);
      cs_run = 0;
    end
    prev_cs = rom_cs_n;
  end

  task automatic pulse_start(input logic st, input logic [7:0] a, input int n);
    @(negedge clk);
    status_mode = st; start_addr = a; byte_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_req(input logic st, input logic [7:0] a, input int n);
    int d0;
    d0 = done_cnt; got = 0; exp_addr = a; exp_stat = st; in_req = 1'b1;
    pulse_start(st, a, n);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int i = 0; i < 40000 && done_cnt == d0; i++) @(negedge clk);
    in_req = 1'b0;
    chk(done_cnt == d0 + 1, "R9 one done", done_cnt - d0, 1);
    chk(!busy, "R9 busy low at end", busy, 0);
    chk(got == n, "R6 byte count", got, n);
    chk(last_bits == (st ? 16 : 24), "R4 bits per transaction", last_bits, st ? 16 : 24);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    total = 0; bad = 0; pre_rises = 0; all_rises = 0; frames = 0; got = 0;
    done_cnt = 0; m_nrise = 0; m_idx = 0; last_bits = 0; hi_run = 0; cs_run = 0;
    m_sh = 0; m_op = 0; m_addr = 0; m_out = 0; exp_addr = 0; exp_stat = 0;
    in_req = 0; prev_cs = 1; rom_miso = 0; finished = 0;
    start = 0; status_mode = 0; start_addr = 0; byte_count = 0;
    do_reset();
    @(negedge clk);
    chk(rom_cs_n && !rom_sck && !rom_mosi && !busy && !done, "R1 reset levels",
        {rom_cs_n, rom_sck, rom_mosi, busy, done}, 5'b10000);

    run_req(1'b0, 8'h20, 3);
    chk(pre_rises == 2, "R2 preamble pulses", pre_rises, 2);
    run_req(1'b0, 8'h9C, 2);
    chk(pre_rises == 2, "R2 preamble once", pre_rises, 2);
    run_req(1'b1, 8'h00, 2);
    @(negedge clk);
    chk(rom_cs_n && !rom_sck && !rom_mosi, "R1 idle levels",
        {rom_cs_n, rom_sck, rom_mosi}, 3'b100);

    begin : zero_count
      int r0, f0, d0;
      r0 = all_rises; f0 = frames; d0 = done_cnt;
      @(negedge clk);
      status_mode = 0; start_addr = 8'h55; byte_count = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !busy, "R11 immediate done", {done, busy}, 2'b10);
      repeat (10) @(negedge clk);
      chk(all_rises == r0 && frames == f0, "R11 no bus activity", all_rises - r0, 0);
      chk(done_cnt == d0 + 1, "R11 single done", done_cnt - d0, 1);
    end

    begin : ignore_busy
      int d0;
      d0 = done_cnt; got = 0; exp_addr = 8'h40; exp_stat = 0; in_req = 1'b1;
      pulse_start(1'b0, 8'h40, 3);
      repeat (30) @(negedge clk);
      pulse_start(1'b1, 8'h80, 5);
      for (int i = 0; i < 40000 && done_cnt == d0; i++) @(negedge clk);
      in_req = 1'b0;
      repeat (20) @(negedge clk);
      chk(got == 3, "R10 start in busy ignored", got, 3);
      chk(done_cnt == d0 + 1 && !busy, "R10 single done", done_cnt - d0, 1);
    end

    run_req(1'b0, 8'h10, 256);
    chk(exp_addr == 8'h10, "R8 full wrap", exp_addr, 8'h10);

    do_reset();
    @(negedge clk);
    chk(rom_cs_n && !rom_sck && !busy, "R1 levels after reset",
        {rom_cs_n, rom_sck, busy}, 3'b100);
    run_req(1'b0, 8'hFE, 4);
    chk(pre_rises == 4, "R2 preamble after reset", pre_rises, 4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule